// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data side of a simple processor. Every internal register and the ALU share one internal bus, and one value moves across it per clock cycle. A separate controller sequences the work one micro-step at a time. Each cycle it chooses which single source drives the bus and which registers capture it. It also picks the ALU function and selects either the operand holding register or the constant 4 as the ALU's first input. Finally, it can ask for a memory read or a memory write.

The second ALU input is always the bus value of the current cycle. The ALU result goes only into the result register. It can reach the bus or any other register only when the result register drives the bus in a later cycle. Memory is reached only through the address register and the data register, over a request and completion handshake. Memory is byte-addressed, so consecutive 32-bit words sit 4 apart. Instruction fetch takes three micro-steps and advances the program counter by 4 through the constant input.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is active and after it is released, the program counter, instruction register, result register, address register and data register are all zero, and neither `mem_rd` nor `mem_wr` nor `mem_wait` is high.
- R2: At a clock edge, each register whose capture enable is high loads the value on the bus, and every register whose enable is low keeps its value. The bus carries the one source whose drive enable is high, and at most one drive enable may be high in any cycle.
- R3: The ALU result is captured only into the result register, on an edge where `z_ie` is high, and appears on the bus only in a later cycle with `z_oe` high. The operation codes are: 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 B, 6 NOT B, 7 B shifted left by one. Here A is the first operand and B is the bus.
- R4: With `const_sel` high, the first ALU operand is the constant 4 instead of the operand holding register. With `const_sel` low, the first operand is the operand holding register.
- R5: `mem_addr` always shows the address register, which is a byte address. The bench memory treats bits 7:2 as the word index.
- R6: A `mem_rd_req` in a cycle raises `mem_rd` from the next cycle on. `mem_rd` stays high up to and including the cycle in which `mem_done` is sampled high, and then falls.
- R7: On the edge that completes a read, the data register captures `mem_rdata`, overriding any bus load in that cycle. A read never writes memory.
- R8: The data register loads from the bus when `mdr_ie` is high, and always drives both the bus (through `mdr_oe`) and `mem_wdata`.
- R9: A `mem_wr_req` raises `mem_wr` from the next cycle until the cycle `mem_done` is sampled high, with `mem_wdata` taken from the data register. The addressed word is then overwritten.
- R10: The instruction register loads from the bus when `ir_ie` is high and is visible on `ir`.
- R11: Instruction fetch works in three micro-steps. Step 1 drives PC onto the bus, loads the address register, requests a read, selects the constant and adds into the result register. Step 2 moves the result register into PC and then waits for completion. Step 3 moves the data register into the instruction register. After these steps, PC has advanced by 4 and `ir` holds the addressed word.
- R12: `mem_wait` is high exactly while a read or write is outstanding, and `mem_rd` and `mem_wr` are never high together. A read request takes priority if both requests arrive in the same cycle.
- R13: The general-purpose register file has `NREG` entries, each with its own drive and capture enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gpr_oe | input | NREG | Per general register: drive the bus |
| pc_oe | input | 1 | Program counter drives the bus |
| mdr_oe | input | 1 | Data register drives the bus |
| z_oe | input | 1 | Result register drives the bus |
| gpr_ie | input | NREG | Per general register: capture the bus |
| pc_ie | input | 1 | Program counter captures the bus |
| mar_ie | input | 1 | Address register captures the bus |
| mdr_ie | input | 1 | Data register captures the bus |
| ir_ie | input | 1 | Instruction register captures the bus |
| y_ie | input | 1 | Operand holding register captures the bus |
| z_ie | input | 1 | Result register captures the ALU output |
| const_sel | input | 1 | First ALU operand is constant 4 instead of the holding register |
| alu_op | input | 3 | ALU function code |
| mem_rd_req | input | 1 | Start a memory read |
| mem_wr_req | input | 1 | Start a memory write |
| mem_rdata | input | DW | Read data from memory |
| mem_done | input | 1 | Memory completes the outstanding access |
| mem_addr | output | DW | Byte address from the address register |
| mem_wdata | output | DW | Write data from the data register |
| mem_rd | output | 1 | Read outstanding |
| mem_wr | output | 1 | Write outstanding |
| mem_wait | output | 1 | An access is outstanding |
| ir | output | DW | Instruction register contents |
| bus_mon | output | DW | Current internal bus value |

## Verification
The assertions assume that the controller enables at most one bus driver per cycle. They also assume that it leaves the address register untouched while a write is outstanding, raises `mem_done` only while an access is outstanding, and issues no new request until `mem_wait` falls. The bench drives every micro-step from tasks that set one driver at a time, and it waits on `mem_wait` before any later step. A monitor in the bench counts any cycle with two drivers enabled. The bench memory raises completion after a programmable latency, and only while `mem_rd` or `mem_wr` is high.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PASS = 3'd5,
    ALU_NOT  = 3'd6,
    ALU_SHL  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_state_e;

  localparam int STEP_BYTES = 4;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic [NREG-1:0]      ie,
  input  logic [DW-1:0]        bus_in,
  output logic [NREG*DW-1:0]   q_flat
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      logic [DW-1:0] d;
      always_comb begin
        d = q;
        if (ie[g]) d = bus_in;
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) q <= '0;
        else         q <= d;
      end
      assign q_flat[g*DW +: DW] = q;
    end
  endgenerate
endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux #(
  parameter int DW   = 32,
  parameter int NSRC = 7
) (
  input  logic [NSRC-1:0]     src_en,
  input  logic [NSRC*DW-1:0]  src_flat,
  output logic [DW-1:0]       bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      bus = bus | (src_flat[i*DW +: DW] & {DW{src_en[i]}});
    end
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [2:0]    op,
  output logic [DW-1:0] res
);
  import sbus_pkg::*;
  alu_op_e sel;
  always_comb begin
    sel = alu_op_e'(op);
    unique case (sel)
      ALU_ADD:  res = opa + opb;
      ALU_SUB:  res = opa - opb;
      ALU_AND:  res = opa & opb;
      ALU_OR:   res = opa | opb;
      ALU_XOR:  res = opa ^ opb;
      ALU_PASS: res = opb;
      ALU_NOT:  res = ~opb;
      ALU_SHL:  res = {opb[DW-2:0], 1'b0};
      default:  res = opb;
    endcase
  end
endmodule

// File: rtl/sbus_memif.sv
module sbus_memif #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic [DW-1:0] bus_in,
  input  logic          mar_ie,
  input  logic          mdr_ie,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_wait
);
  import sbus_pkg::*;

  acc_state_e    st_q, st_d;
  logic [DW-1:0] mar_d, mdr_d;
  logic          rd_fin;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ACC_IDLE: begin
        if (rd_req)      st_d = ACC_RD;
        else if (wr_req) st_d = ACC_WR;
      end
      ACC_RD:  if (mem_done) st_d = ACC_IDLE;
      ACC_WR:  if (mem_done) st_d = ACC_IDLE;
      default: st_d = ACC_IDLE;
    endcase
  end

  assign rd_fin = (st_q == ACC_RD) && mem_done;

  always_comb begin
    mar_d = mar_q;
    if (mar_ie) mar_d = bus_in;
    mdr_d = mdr_q;
    if (rd_fin)      mdr_d = mem_rdata;
    else if (mdr_ie) mdr_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= ACC_IDLE;
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      st_q  <= st_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
    end
  end

  assign mem_rd   = (st_q == ACC_RD);
  assign mem_wr   = (st_q == ACC_WR);
  assign mem_wait = (st_q != ACC_IDLE);
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] gpr_oe,
  input  logic            pc_oe,
  input  logic            mdr_oe,
  input  logic            z_oe,
  input  logic [NREG-1:0] gpr_ie,
  input  logic            pc_ie,
  input  logic            mar_ie,
  input  logic            mdr_ie,
  input  logic            ir_ie,
  input  logic            y_ie,
  input  logic            z_ie,
  input  logic            const_sel,
  input  logic [2:0]      alu_op,
  input  logic            mem_rd_req,
  input  logic            mem_wr_req,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_done,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_wait,
  output logic [DW-1:0]   ir,
  output logic [DW-1:0]   bus_mon
);
  import sbus_pkg::*;

  localparam int NSRC = NREG + 3;
  localparam logic [DW-1:0] STEP = DW'(STEP_BYTES);

  logic rst_s0, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_sn <= rst_s0;
    end
  end

  logic [DW-1:0]      bus;
  logic [NREG*DW-1:0] gpr_flat;
  logic [DW-1:0]      pc_q, pc_d, ir_q, ir_d, y_q, y_d, z_q, z_d;
  logic [DW-1:0]      mdr_q, mar_q, alu_a, alu_res;
  logic [NSRC-1:0]    src_en;
  logic [NSRC*DW-1:0] src_flat;

  sbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_sn(rst_sn), .ie(gpr_ie), .bus_in(bus), .q_flat(gpr_flat)
  );

  assign src_en   = {z_oe, mdr_oe, pc_oe, gpr_oe};
  assign src_flat = {z_q, mdr_q, pc_q, gpr_flat};

  sbus_busmux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .src_en(src_en), .src_flat(src_flat), .bus(bus)
  );

  assign alu_a = const_sel ? STEP : y_q;

  sbus_alu #(.DW(DW)) u_alu (
    .opa(alu_a), .opb(bus), .op(alu_op), .res(alu_res)
  );

  sbus_memif #(.DW(DW)) u_mem (
    .clk(clk), .rst_sn(rst_sn), .bus_in(bus), .mar_ie(mar_ie), .mdr_ie(mdr_ie),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req), .mem_rdata(mem_rdata),
    .mem_done(mem_done), .mar_q(mar_q), .mdr_q(mdr_q), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wait(mem_wait)
  );

  always_comb begin
    pc_d = pc_q;
    if (pc_ie) pc_d = bus;
    ir_d = ir_q;
    if (ir_ie) ir_d = bus;
    y_d = y_q;
    if (y_ie) y_d = bus;
    z_d = z_q;
    if (z_ie) z_d = alu_res;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pc_q <= '0;
      ir_q <= '0;
      y_q  <= '0;
      z_q  <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= ir_d;
      y_q  <= y_d;
      z_q  <= z_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign ir        = ir_q;
  assign bus_mon   = bus;
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_sn,
  input logic [NREG-1:0] gpr_oe,
  input logic            pc_oe,
  input logic            mdr_oe,
  input logic            z_oe,
  input logic            pc_ie,
  input logic            z_ie,
  input logic            const_sel,
  input logic [2:0]      alu_op,
  input logic [DW-1:0]   bus_mon,
  input logic [DW-1:0]   pc_q,
  input logic [DW-1:0]   z_q,
  input logic [DW-1:0]   mdr_q,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            mem_wait,
  input logic            mem_done,
  input logic [DW-1:0]   mem_rdata,
  input logic [DW-1:0]   mem_addr
);
  localparam logic [DW-1:0] STEP = DW'(sbus_pkg::STEP_BYTES);

  p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({gpr_oe, pc_oe, mdr_oe, z_oe}));

  p_pc_capture_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    pc_ie |=> (pc_q == $past(bus_mon)));

  p_step_add_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (z_ie && const_sel && alu_op == 3'd0) |=> (z_q == $past(bus_mon) + STEP));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_rd && !mem_done) |=> mem_rd);

  p_rd_capture_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_rd && mem_done) |=> (mdr_q == $past(mem_rdata)));

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_wr && !mem_done) |=> (mem_wr && $stable(mem_addr)));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_rd && mem_wr));

  p_wait_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_wait == (mem_rd || mem_wr));
endmodule

bind sbus_datapath sbus_checker #(.DW(DW), .NREG(NREG)) u_chk (.*);

// File: tb/sim_sbus_datapath.sv
module sim_sbus_datapath;
  localparam int DW = 32;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREG-1:0] gpr_oe, gpr_ie;
  logic pc_oe, mdr_oe, z_oe, pc_ie, mar_ie, mdr_ie, ir_ie, y_ie, z_ie;
  logic const_sel, mem_rd_req, mem_wr_req, mem_done;
  logic [2:0] alu_op;
  logic [DW-1:0] mem_rdata, mem_addr, mem_wdata, ir, bus_mon;
  logic mem_rd, mem_wr, mem_wait;

  int checks = 0;
  int errors = 0;
  int conflicts = 0;
  int writes = 0;
  int lat = 3;
  int lat_cnt = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] pc_m = '0;
  logic [DW-1:0] rv [NREG];

  always #10 clk = ~clk;

  sbus_datapath #(.DW(DW), .NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .gpr_oe(gpr_oe), .pc_oe(pc_oe), .mdr_oe(mdr_oe),
    .z_oe(z_oe), .gpr_ie(gpr_ie), .pc_ie(pc_ie), .mar_ie(mar_ie), .mdr_ie(mdr_ie),
    .ir_ie(ir_ie), .y_ie(y_ie), .z_ie(z_ie), .const_sel(const_sel), .alu_op(alu_op),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_rdata(mem_rdata),
    .mem_done(mem_done), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wait(mem_wait), .ir(ir), .bus_mon(bus_mon)
  );

  // memory model: completes after lat falling edges of an active access
  always @(negedge clk) begin
    if (!(mem_rd || mem_wr)) begin
      lat_cnt  <= 0;
      mem_done <= 1'b0;
    end else if (!mem_done) begin
      if (lat_cnt >= lat - 1) begin
        mem_done  <= 1'b1;
        mem_rdata <= mem[mem_addr[7:2]];
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_wr && mem_done) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      writes <= writes + 1;
    end
    if ($countones({gpr_oe, pc_oe, mdr_oe, z_oe}) > 1) conflicts <= conflicts + 1;
  end

  task automatic clr();
    gpr_oe = '0; gpr_ie = '0; pc_oe = 0; mdr_oe = 0; z_oe = 0; pc_ie = 0;
    mar_ie = 0; mdr_ie = 0; ir_ie = 0; y_ie = 0; z_ie = 0; const_sel = 0;
    alu_op = 3'd0; mem_rd_req = 0; mem_wr_req = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample(output logic [DW-1:0] v);
    #5;
    v = bus_mon;
  endtask

  task automatic wait_mem(input bit is_rd);
    int n = 0;
    while (mem_wait && n < 50) begin
      chk(is_rd ? "R6 mem_rd held while waiting" : "R9 mem_wr held while waiting",
          is_rd ? 32'(mem_rd) : 32'(mem_wr), 32'd1);
      tick();
      n++;
    end
  endtask

  task automatic peek_gpr(input int r, output logic [DW-1:0] v);
    gpr_oe[r] = 1'b1;
    sample(v);
    tick();
  endtask

  // three-step fetch; dst < 0 targets the instruction register
  task automatic fetch_into(input int dst);
    pc_oe = 1; mar_ie = 1; mem_rd_req = 1; const_sel = 1; alu_op = 3'd0; z_ie = 1;
    tick();
    z_oe = 1; pc_ie = 1;
    tick();
    pc_m = pc_m + 4;
    wait_mem(1'b1);
    mdr_oe = 1;
    if (dst < 0) ir_ie = 1; else gpr_ie[dst] = 1'b1;
    tick();
  endtask

  task automatic load_reg(input int r, input logic [DW-1:0] val);
    mem[pc_m[7:2]] = val;
    fetch_into(r);
    rv[r] = val;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 mem_rd after reset", 32'(mem_rd), 0);
    chk("R1 mem_wr after reset", 32'(mem_wr), 0);
    chk("R1 mem_wait after reset", 32'(mem_wait), 0);
    chk("R1 mem_addr after reset", mem_addr, 0);
    chk("R1 mem_wdata after reset", mem_wdata, 0);
    chk("R1 ir after reset", ir, 0);
    pc_oe = 1; sample(v); tick();
    chk("R1 pc after reset", v, 0);
    z_oe = 1; sample(v); tick();
    chk("R1 z after reset", v, 0);
  endtask

  task automatic t_fetch();
    logic [DW-1:0] v;
    int w0;
    w0 = writes;
    lat = 3;
    mem[0] = 32'hCAFE_0001;
    pc_oe = 1; mar_ie = 1; mem_rd_req = 1; const_sel = 1; alu_op = 3'd0; z_ie = 1;
    sample(v);
    chk("R11 step1 bus carries pc", v, 0);
    tick();
    chk("R5 mem_addr is pc", mem_addr, 0);
    chk("R6 mem_rd raised", 32'(mem_rd), 1);
    chk("R12 mem_wait raised", 32'(mem_wait), 1);
    z_oe = 1; pc_ie = 1;
    sample(v);
    chk("R4 pc plus step in z", v, 32'd4);
    tick();
    pc_m = 4;
    wait_mem(1'b1);
    chk("R6 mem_rd dropped", 32'(mem_rd), 0);
    mdr_oe = 1; ir_ie = 1;
    tick();
    chk("R10 R11 ir holds fetched word", ir, 32'hCAFE_0001);
    pc_oe = 1; sample(v); tick();
    chk("R11 pc advanced", v, 32'd4);
    chk("R7 read wrote nothing", 32'(writes - w0), 0);
    chk("R7 memory word intact", mem[0], 32'hCAFE_0001);
  endtask

  task automatic t_transfer();
    logic [DW-1:0] v;
    load_reg(0, 32'h1234_5678);
    load_reg(1, 32'h0BAD_F00D);
    load_reg(3, 32'h5555_AAAA);
    gpr_oe[1] = 1; gpr_ie[2] = 1;
    tick();
    rv[2] = rv[1];
    peek_gpr(2, v); chk("R2 R13 r2 copy of r1", v, 32'h0BAD_F00D);
    peek_gpr(1, v); chk("R2 source kept", v, 32'h0BAD_F00D);
    peek_gpr(0, v); chk("R2 r0 untouched", v, 32'h1234_5678);
    peek_gpr(3, v); chk("R13 r3 untouched", v, 32'h5555_AAAA);
  endtask

  function automatic logic [DW-1:0] ref_alu(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return b;
      6: return ~b;
      default: return b << 1;
    endcase
  endfunction

  task automatic t_alu();
    logic [DW-1:0] v;
    for (int op = 0; op < 8; op++) begin
      gpr_oe[0] = 1; y_ie = 1;
      tick();
      gpr_oe[1] = 1; alu_op = 3'(op); z_ie = 1;
      sample(v);
      chk("R3 result not on bus yet", v, rv[1]);
      tick();
      z_oe = 1;
      sample(v);
      chk($sformatf("R3 alu op %0d", op), v, ref_alu(op, rv[0], rv[1]));
      tick();
    end
  endtask

  task automatic t_const();
    logic [DW-1:0] v;
    gpr_oe[3] = 1; const_sel = 1; alu_op = 3'd0; z_ie = 1; tick();
    z_oe = 1; sample(v); tick();
    chk("R4 const add ignores y", v, rv[3] + 32'd4);
    gpr_oe[3] = 1; const_sel = 1; alu_op = 3'd1; z_ie = 1; tick();
    z_oe = 1; sample(v); tick();
    chk("R4 const sub", v, 32'd4 - rv[3]);
    gpr_oe[3] = 1; const_sel = 0; alu_op = 3'd0; z_ie = 1; tick();
    z_oe = 1; sample(v); tick();
    chk("R4 y used when const off", v, rv[0] + rv[3]);
  endtask

  task automatic t_store();
    logic [DW-1:0] v;
    int w0;
    lat = 5;
    load_reg(2, 32'h0000_0040);
    mem[16] = 32'hDEAD_0000;
    gpr_oe[2] = 1; mar_ie = 1; tick();
    chk("R5 mem_addr from address register", mem_addr, 32'h40);
    gpr_oe[3] = 1; mdr_ie = 1; tick();
    chk("R8 mem_wdata follows data register", mem_wdata, rv[3]);
    w0 = writes;
    mem_wr_req = 1; tick();
    chk("R9 mem_wr raised", 32'(mem_wr), 1);
    chk("R12 no read during write", 32'(mem_rd), 0);
    chk("R12 mem_wait during write", 32'(mem_wait), 1);
    wait_mem(1'b0);
    chk("R9 mem_wr dropped", 32'(mem_wr), 0);
    chk("R9 one write done", 32'(writes - w0), 1);
    chk("R9 word overwritten", mem[16], rv[3]);
    // overwrite data register from bus, then read back: memory wins
    gpr_oe[0] = 1; mdr_ie = 1; tick();
    mdr_oe = 1; sample(v); tick();
    chk("R8 data register from bus", v, rv[0]);
    w0 = writes;
    mem_rd_req = 1; tick();
    wait_mem(1'b1);
    mdr_oe = 1; sample(v); tick();
    chk("R7 data register from memory", v, rv[3]);
    chk("R7 readback wrote nothing", 32'(writes - w0), 0);
  endtask

  task automatic t_priority();
    lat = 1;
    mem_rd_req = 1; mem_wr_req = 1; tick();
    chk("R12 read wins", 32'(mem_rd), 1);
    chk("R12 write suppressed", 32'(mem_wr), 0);
    wait_mem(1'b1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'(i) * 32'h0101_0101;
    mem_done = 1'b0;
    mem_rdata = '0;
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fetch();
    t_transfer();
    t_alu();
    t_const();
    t_store();
    t_priority();
    chk("R2 single driver per cycle", 32'(conflicts), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule